// File: doc/BRIEF.md
# Microsecond Limit Counter/Timer

This block holds a system timer and one timer per CPU. Every timer advances on a microsecond strobe that arrives from outside the block. A timer in limit mode counts up toward a programmed limit. When it reaches that limit it starts again from one and raises a level interrupt. The interrupt stays high until software reads the timer's limit word. The system timer feeds interrupt level 10, and each CPU timer feeds level 14 of its own CPU.

Software reaches the block through a single-cycle word bus. Read data is combinational on the addressed word, and any side effect of an access takes place at the clock edge. Each timer has a limit word, a count word and a second copy of the limit word whose reads leave the interrupt alone. Each CPU timer also has a run-control word. A configuration word in the system block sets each CPU timer to limit mode or to free-running user mode. To get a period of P microseconds, software writes (P+1) shifted left by ten.

Top module: `usec_timer`

## Requirements
- R1: Reset clears every count, limit, pending flag and run bit, and the configuration word. Both interrupt outputs are low after reset.
- R2: The word address is {timer index, word index}. The timer index is bits 5:3: values 0 to NUM_CPU-1 select the CPU timers and NUM_CPU selects the system timer. The word index is bits 2:0: 0 is limit, 1 is count, 2 is the non-clearing limit copy, 3 is run control (CPU timers only), and 4 is configuration (system block only). Every other word reads as zero and ignores writes. Writes to the count word are also ignored.
- R3: Limit and count values are 21 bits held in word bits 30:10. Reads of these words return the timer's pending flag in bit 31 and zeros in bits 9:0. A run-control read returns the run bit in bit 0. A configuration read returns the per-CPU mode bits in bits NUM_CPU-1:0.
- R4: In limit mode each strobe adds one to the count. If the incremented value equals a nonzero limit, the count becomes 1 and the pending flag sets. A limit of L therefore gives one interrupt every L-1 strobes.
- R5: A write to the limit word loads the limit and sets the count to 1 in the same cycle. It overrides a strobe in that cycle, and that strobe cannot cause a match.
- R6: A write to the non-clearing limit copy loads the limit and leaves the count unchanged. A strobe in that cycle is compared against the previous limit.
- R7: A read of the limit word clears that timer's pending flag. A read of the non-clearing copy does not clear it.
- R8: If a limit match happens in the same cycle as a limit-word read, the pending flag remains set.
- R9: With a limit of zero the timer never sets its pending flag, and the count wraps modulo 2^21.
- R10: Configuration bit i set to 1 puts CPU timer i in user mode. In user mode the timer counts on each strobe only while its run bit is 1, and no limit match is raised. The system timer is always in limit mode.
- R11: irq_sys follows the system timer's pending flag and irq_cpu[i] follows CPU timer i's flag. An interrupt output rises only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle microsecond strobe |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Word address {timer, word} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| irq_sys | output | 1 | System timer interrupt (level 10) |
| irq_cpu | output | NUM_CPU | Per-CPU timer interrupts (level 14) |

## Verification
The case that needs the most care is a limit match that falls in the same cycle as the read that acknowledges the interrupt. The directed sequence places a limit-word read on exactly the strobe that completes a period, and expects the pending flag to stay set rather than be lost. A limit write on a strobe cycle is provoked the same way and must leave the count at one. Random traffic mixes strobes with every bus access. A bench model applies the same priorities and judges every read and every interrupt output.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int VAL_LSB = 10;
    localparam int VAL_W   = 21;

    typedef enum logic [2:0] {
        W_LIMIT    = 3'd0,
        W_COUNT    = 3'd1,
        W_LIMIT_NC = 3'd2,
        W_RUNCTL   = 3'd3,
        W_MODECFG  = 3'd4
    } word_e;

    typedef struct packed {
        logic wr_limit;
        logic wr_alias;
        logic wr_run;
        logic rd_ack;
    } tmr_cmd_t;

    typedef struct packed {
        logic [VAL_W-1:0] cnt;
        logic [VAL_W-1:0] lim;
        logic             pend;
        logic             run;
    } tmr_state_t;

    function automatic logic [VAL_W-1:0] val_of(input logic [31:0] w);
        return w[VAL_LSB +: VAL_W];
    endfunction

    function automatic logic [31:0] val_word(input logic flag, input logic [VAL_W-1:0] v);
        return {flag, v, {VAL_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int TSEL_W  = 3,
    localparam int NUM_TMR = NUM_CPU + 1,
    localparam int ADDR_W  = TSEL_W + 3
) (
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    output tmr_cmd_t [NUM_TMR-1:0]   cmd,
    output logic                     wr_cfg,
    output logic [TSEL_W-1:0]        tsel,
    output word_e                    wsel
);
    assign tsel = bus_addr[ADDR_W-1:3];
    assign wsel = word_e'(bus_addr[2:0]);

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_dec
        logic here;
        assign here = bus_sel && (32'(tsel) == t);
        assign cmd[t].wr_limit = here && bus_wr && (wsel == W_LIMIT);
        assign cmd[t].wr_alias = here && bus_wr && (wsel == W_LIMIT_NC);
        assign cmd[t].wr_run   = here && bus_wr && (wsel == W_RUNCTL) && (t < NUM_CPU);
        assign cmd[t].rd_ack   = here && !bus_wr && (wsel == W_LIMIT);
    end

    assign wr_cfg = bus_sel && bus_wr && (32'(tsel) == NUM_CPU) && (wsel == W_MODECFG);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter bit HAS_USER = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             user_mode,
    input  tmr_cmd_t         cmd,
    input  logic [VAL_W-1:0] wval,
    input  logic             wrun,
    output tmr_state_t       st
);
    logic [VAL_W-1:0] cnt_q, lim_q, inc;
    logic             pend_q, run_q, usr, advance, hit;

    assign usr     = HAS_USER && user_mode;
    assign inc     = cnt_q + VAL_W'(1);
    assign advance = tick && (!usr || run_q);
    assign hit     = tick && !usr && !cmd.wr_limit && (lim_q != '0) && (inc == lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            lim_q  <= '0;
            pend_q <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            if (cmd.wr_limit || cmd.wr_alias)
                lim_q <= wval;
            if (cmd.wr_limit)
                cnt_q <= VAL_W'(1);
            else if (advance)
                cnt_q <= hit ? VAL_W'(1) : inc;
            if (hit)
                pend_q <= 1'b1;
            else if (cmd.rd_ack)
                pend_q <= 1'b0;
            if (HAS_USER && cmd.wr_run)
                run_q <= wrun;
        end
    end

    assign st = '{cnt: cnt_q, lim: lim_q, pend: pend_q, run: run_q};
endmodule

// File: rtl/usec_timer.sv
module usec_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int NUM_TMR = NUM_CPU + 1,
    localparam int TSEL_W  = $clog2(NUM_TMR),
    localparam int ADDR_W  = TSEL_W + 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               us_tick,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_sys,
    output logic [NUM_CPU-1:0] irq_cpu
);
    tmr_cmd_t [NUM_TMR-1:0] cmd;
    tmr_state_t             st [NUM_TMR];
    logic                   wr_cfg;
    logic [TSEL_W-1:0]      tsel;
    word_e                  wsel;
    logic [NUM_CPU-1:0]     cfg_q;

    tmr_decode #(.NUM_CPU(NUM_CPU), .TSEL_W(TSEL_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .cmd      (cmd),
        .wr_cfg   (wr_cfg),
        .tsel     (tsel),
        .wsel     (wsel)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        localparam bit IS_CPU = (t < NUM_CPU);
        logic umode;
        if (IS_CPU) begin : g_mode
            assign umode = cfg_q[t];
        end else begin : g_sys
            assign umode = 1'b0;
        end
        tmr_unit #(.HAS_USER(IS_CPU)) u_tmr (
            .clk       (clk),
            .rst       (rst),
            .tick      (us_tick),
            .user_mode (umode),
            .cmd       (cmd[t]),
            .wval      (val_of(bus_wdata)),
            .wrun      (bus_wdata[0]),
            .st        (st[t])
        );
        if (IS_CPU) begin : g_irq
            assign irq_cpu[t] = st[t].pend;
        end else begin : g_sirq
            assign irq_sys = st[t].pend;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_cfg)
            cfg_q <= bus_wdata[NUM_CPU-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        for (int t = 0; t < NUM_TMR; t++) begin
            if (32'(tsel) == t) begin
                case (wsel)
                    W_LIMIT, W_LIMIT_NC: bus_rdata = val_word(st[t].pend, st[t].lim);
                    W_COUNT:             bus_rdata = val_word(st[t].pend, st[t].cnt);
                    W_RUNCTL:            if (t < NUM_CPU) bus_rdata = {31'b0, st[t].run};
                    W_MODECFG:           if (t == NUM_CPU) bus_rdata = 32'(cfg_q);
                    default:             bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 6,
    localparam int NUM_TMR = NUM_CPU + 1
) (
    input logic               clk,
    input logic               rst,
    input logic               us_tick,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               irq_sys,
    input logic [NUM_CPU-1:0] irq_cpu,
    input logic [NUM_CPU-1:0] cfg_q
);
    logic [NUM_TMR-1:0] irq_v;
    assign irq_v = {irq_sys, irq_cpu};

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!irq_sys && (irq_cpu == '0)));

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_t
        logic rd_lim;
        assign rd_lim = bus_sel && !bus_wr && (bus_addr == ADDR_W'(t * 8));

        assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
            (rd_lim && !us_tick) |=> !irq_v[t]);

        assert_rise_after_tick_R11: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_v[t]) |-> $past(us_tick));
    end

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_c
        assert_user_quiet_R10: assert property (@(posedge clk) disable iff (rst)
            $past(cfg_q[i]) |-> !$rose(irq_cpu[i]));
    end
endmodule

bind usec_timer tmr_checker #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .us_tick  (us_tick),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .irq_sys  (irq_sys),
    .irq_cpu  (irq_cpu),
    .cfg_q    (cfg_q)
);

// File: tb/test_usec_timer.sv
module test_usec_timer;
    localparam int NC = 4;
    localparam int NT = NC + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        us_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_sys;
    logic [NC-1:0] irq_cpu;

    usec_timer #(.NUM_CPU(NC)) i_usec_timer (
        .clk(clk), .rst(rst), .us_tick(us_tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_sys(irq_sys), .irq_cpu(irq_cpu)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [20:0] m_cnt [NT];
    logic [20:0] m_lim [NT];
    bit          m_pend [NT];
    bit          m_run [NT];
    logic [NC-1:0] m_cfg;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        int t = int'(a[5:3]);
        int r = int'(a[2:0]);
        if (t >= NT) return 32'h0;
        case (r)
            0, 2: return {m_pend[t], m_lim[t], 10'b0};
            1:    return {m_pend[t], m_cnt[t], 10'b0};
            3:    return (t < NC) ? {31'b0, m_run[t]} : 32'h0;
            4:    return (t == NC) ? 32'(m_cfg) : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_irq();
        logic [31:0] v = '0;
        for (int t = 0; t < NT; t++) v[t] = m_pend[t];
        return v;
    endfunction

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            m_cnt[t] = '0; m_lim[t] = '0; m_pend[t] = 0; m_run[t] = 0;
        end
        m_cfg = '0;
    endtask

    task automatic model_step(input bit tk, input bit sel, input bit wr,
                              input logic [5:0] a, input logic [31:0] wd);
        int ta = int'(a[5:3]);
        int r  = int'(a[2:0]);
        for (int t = 0; t < NT; t++) begin
            bit usr = (t < NC) && m_cfg[t];
            bit wl  = sel && wr && ta == t && r == 0;
            bit wa  = sel && wr && ta == t && r == 2;
            bit wc  = sel && wr && ta == t && r == 3 && t < NC;
            bit ra  = sel && !wr && ta == t && r == 0;
            logic [20:0] inc = m_cnt[t] + 21'd1;
            bit hit = tk && !usr && !wl && m_lim[t] != 0 && inc == m_lim[t];
            if (wl) m_cnt[t] = 21'd1;
            else if (tk && (!usr || m_run[t])) m_cnt[t] = hit ? 21'd1 : inc;
            if (wl || wa) m_lim[t] = wd[30:10];
            if (hit) m_pend[t] = 1;
            else if (ra) m_pend[t] = 0;
            if (wc) m_run[t] = wd[0];
        end
        if (sel && wr && ta == NC && r == 4) m_cfg = wd[NC-1:0];
    endtask

    task automatic step(input bit tk, input bit sel, input bit wr, input logic [5:0] a,
                        input logic [31:0] wd, input string req);
        @(negedge clk);
        us_tick = tk; bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        #1;
        if (sel && !wr) check(req, bus_rdata, exp_read(a));
        @(posedge clk);
        model_step(tk, sel, wr, a, wd);
        #1;
        check("R11", 32'({irq_sys, irq_cpu}), exp_irq());
    endtask

    task automatic ticks(input int n, input string req);
        for (int k = 0; k < n; k++) step(1, 0, 0, 6'd0, 32'd0, req);
    endtask

    function automatic logic [5:0] ad(input int t, input int r);
        return {3'(t), 3'(r)};
    endfunction

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check("R1", 32'({irq_sys, irq_cpu}), 32'h0);
        for (int t = 0; t < NT; t++)
            for (int r = 0; r < 5; r++) step(0, 1, 0, ad(t, r), 0, "R1");

        // R2: unmapped words and count writes
        step(0, 1, 1, ad(NC, 1), 32'hFFFF_FC00, "R2");
        step(0, 1, 1, ad(0, 5), 32'hFFFF_FFFF, "R2");
        step(0, 1, 0, ad(NC, 1), 0, "R2");
        step(0, 1, 0, ad(0, 5), 0, "R2");
        step(0, 1, 0, ad(7, 0), 0, "R2");

        // R5 / R4: system timer, period 5
        step(0, 1, 1, ad(NC, 0), (32'd5 + 1) << 10, "R5");
        step(0, 1, 0, ad(NC, 1), 0, "R5");
        check("R5", bus_rdata, 32'h0000_0400);
        ticks(4, "R4");
        check("R4", 32'(irq_sys), 32'h0);
        ticks(1, "R4");
        check("R4", 32'(irq_sys), 32'h1);
        step(0, 1, 0, ad(NC, 2), 0, "R7");
        check("R7", 32'(irq_sys), 32'h1);
        step(0, 1, 0, ad(NC, 0), 0, "R7");
        check("R7", 32'(irq_sys), 32'h0);

        // R8: acknowledge read on the matching strobe
        ticks(4, "R4");
        step(1, 1, 0, ad(NC, 0), 0, "R8");
        check("R8", 32'(irq_sys), 32'h1);
        step(0, 1, 0, ad(NC, 0), 0, "R7");

        // R5: limit write on a strobe cycle
        ticks(2, "R4");
        step(1, 1, 1, ad(NC, 0), 32'd10 << 10, "R5");
        step(0, 1, 0, ad(NC, 1), 0, "R5");
        check("R5", bus_rdata, 32'h0000_0400);

        // R6: non-clearing copy write keeps the count
        ticks(3, "R6");
        step(1, 1, 1, ad(NC, 2), 32'd20 << 10, "R6");
        step(0, 1, 0, ad(NC, 1), 0, "R6");
        check("R6", bus_rdata, 32'd5 << 10);

        // R9: zero limit never interrupts
        ticks(30, "R9");
        check("R9", 32'(irq_cpu[0]), 32'h0);
        step(0, 1, 0, ad(0, 1), 0, "R9");

        // R10: user mode on CPU timer 1
        step(0, 1, 1, ad(NC, 4), 32'h2, "R10");
        step(0, 1, 1, ad(1, 0), 32'd3 << 10, "R10");
        ticks(5, "R10");
        step(0, 1, 0, ad(1, 1), 0, "R10");
        check("R10", bus_rdata, 32'd1 << 10);
        step(0, 1, 1, ad(1, 3), 32'h1, "R10");
        ticks(6, "R10");
        check("R10", 32'(irq_cpu[1]), 32'h0);
        step(0, 1, 0, ad(1, 1), 0, "R10");
        check("R10", bus_rdata, 32'd7 << 10);
        step(0, 1, 0, ad(1, 3), 0, "R3");
        step(0, 1, 0, ad(NC, 4), 0, "R3");
        check("R3", bus_rdata, 32'h2);

        // random traffic
        for (int k = 0; k < 3000; k++) begin
            bit tk = ($urandom % 3) == 0;
            bit sel = ($urandom % 2) == 0;
            bit wr = ($urandom % 3) == 0;
            logic [5:0] a = {3'($urandom % 6), 3'($urandom % 6)};
            logic [31:0] wd = {1'($urandom), 21'($urandom % 12), 10'($urandom)};
            if (a[2:0] == 3'd4) wd = 32'($urandom);
            step(tk, sel, wr, a, wd, "R4");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule